// File: doc/BRIEF.md
# Auto-Acknowledging Prioritized Interrupt Controller

This block collects level-sensitive interrupt lines from the rest of the chip and routes each one to exactly one of a small group of processors. Every line has a mask bit, a software-trigger bit and a one-hot target register. A line asks for service when its hardware input or its software-trigger bit is high. Each processor has its own interrupt output, which is high while any line routed to it asks for service and is unmasked.

A processor services its interrupts by reading the event register. The read returns the lowest-numbered line that is requesting, unmasked and routed to that processor, and the same read masks that line. The handler clears the mask bit when it is done, which ends the interrupt. When nothing is left, the event register reads zero, so a handler can simply loop until it sees zero.

The register bus is simple. An access lasts as long as `bus_sel` is high, and it may stall for any number of cycles. Its side effects happen only in the first cycle. A sideband on every access names the processor that issues it.

Top module: `irqc_top`

## Requirements
- R1: After reset, every mask bit is 1, every software-trigger bit is 0, every target register reads 1 (processor 0), and every `irq_out` bit is low.
- R2: Writing 1s to MASK_SET (byte 0x100 + 4*w) sets mask bits, and writing 1s to MASK_CLR (0x180 + 4*w) clears them; zero bits change nothing. Line n sits in word w = n/32 at bit n%32. A read of either address returns the current mask word.
- R3: The software-trigger bits use the same layout, with SWT_SET at 0x200 + 4*w and SWT_CLR at 0x280 + 4*w. A line's request is its hardware input ORed with its software-trigger bit.
- R4: The target register of line n is at 0x400 + 4*n and holds a one-hot processor mask in bits N_CPUS-1:0. Only the processors selected there see the line.
- R5: A read of EVENT (0x008) returns type 1 in bits 31:16 and the winning line number in bits 15:0. When several lines qualify, the lowest-numbered line wins.
- R6: The event read that returns a line sets that line's mask bit at the same clock edge that captures the read data.
- R7: When no line is requesting, unmasked and routed to the reading processor, the event read returns 0 and changes no mask bit.
- R8: INFO (0x000) returns N_LINES in bits 15:0. WHOAMI (0x004) returns the `bus_cpu` value of the access.
- R9: `irq_out[c]` is high exactly when at least one line is requesting, unmasked and routed to processor c.
- R10: An access starts in the first cycle in which `bus_sel` is high. Writes and mask side effects happen only in that cycle. Read data is valid from the next cycle and is held until the next access starts. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | High for the duration of an access |
| bus_we | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Index of the processor issuing the access |
| bus_rdata | output | 32 | Read data, registered |
| line_in | input | N_LINES | Level-sensitive interrupt lines |
| irq_out | output | N_CPUS | Interrupt request, one per processor |

## Verification
A sweep drives one hardware line at a time across all 64 lines. Each line is routed to a rotating processor and is read from both the owning processor and a non-owner. This separates a routing or index error from a priority error, and it shows that the read masks exactly the bit it reports. Mixed patterns of hardware lines and software-trigger bits, with randomly drawn targets, are then drained processor by processor until the event register reads zero. Every return is compared with the lowest qualifying line of an arithmetic model, which exposes a wrong priority direction, a lost software OR, or a double mask. Every access is held for two cycles, and the read data and the mask words are compared after the stall, so a side effect that repeats during a stalled access is caught.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  // fixed word addresses (byte address bits 11:2)
  localparam logic [9:0] WA_INFO   = 10'd0;
  localparam logic [9:0] WA_WHOAMI = 10'd1;
  localparam logic [9:0] WA_EVENT  = 10'd2;

  // 128-byte bit-array regions (byte address bits 11:7)
  localparam logic [4:0] RG_MASK_SET = 5'd2;
  localparam logic [4:0] RG_MASK_CLR = 5'd3;
  localparam logic [4:0] RG_SWT_SET  = 5'd4;
  localparam logic [4:0] RG_SWT_CLR  = 5'd5;

  // target region (byte address bits 11:10)
  localparam logic [1:0] RG_TARGET = 2'b01;

  localparam logic [15:0] EVT_TYPE_LINE = 16'd1;
endpackage

// File: rtl/irqc_pick.sv
// Lowest-index-wins selection over one processor's eligible lines.
module irqc_pick #(
  parameter int N_LINES = 64,
  parameter int IDX_W   = 6
) (
  input  logic [N_LINES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irqc_regs.sv
// Per-line state: mask, software trigger and target processor.
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int N_CPUS  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_go,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [N_LINES-1:0]              evt_mask,
  output logic [N_LINES-1:0]              mask_q,
  output logic [N_LINES-1:0]              swt_q,
  output logic [N_LINES-1:0][N_CPUS-1:0]  tgt_q
);
  logic [N_LINES-1:0]             mask_d;
  logic [N_LINES-1:0]             swt_d;
  logic [N_LINES-1:0][N_CPUS-1:0] tgt_d;
  logic [4:0]                     rg;
  logic [4:0]                     wsel;
  logic [7:0]                     tsel;
  logic                           is_tgt;

  assign rg     = wr_addr[11:7];
  assign wsel   = wr_addr[6:2];
  assign tsel   = wr_addr[9:2];
  assign is_tgt = wr_addr[11:10] == RG_TARGET;

  always_comb begin
    mask_d = mask_q;
    swt_d  = swt_q;
    tgt_d  = tgt_q;
    for (int i = 0; i < N_LINES; i++) begin
      if (wr_go && wsel == 5'(i / 32) && wr_data[i % 32]) begin
        if (rg == RG_MASK_SET) mask_d[i] = 1'b1;
        if (rg == RG_MASK_CLR) mask_d[i] = 1'b0;
        if (rg == RG_SWT_SET)  swt_d[i]  = 1'b1;
        if (rg == RG_SWT_CLR)  swt_d[i]  = 1'b0;
      end
      if (wr_go && is_tgt && tsel == 8'(i)) tgt_d[i] = wr_data[N_CPUS-1:0];
      if (evt_mask[i]) mask_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      swt_q  <= '0;
      for (int i = 0; i < N_LINES; i++) tgt_q[i] <= N_CPUS'(1);
    end else begin
      mask_q <= mask_d;
      swt_q  <= swt_d;
      tgt_q  <= tgt_d;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int N_CPUS  = 4,
  parameter int CPU_W   = (N_CPUS > 1) ? $clog2(N_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [CPU_W-1:0]     bus_cpu,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [N_LINES-1:0]   line_in,
  output logic [N_CPUS-1:0]    irq_out
);
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // access framing
  logic sel_q;
  logic acc_go;
  logic wr_go;
  logic rd_go;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) sel_q <= 1'b0;
    else          sel_q <= bus_sel;
  end

  assign acc_go = bus_sel & ~sel_q;
  assign wr_go  = acc_go & bus_we;
  assign rd_go  = acc_go & ~bus_we;

  // per-line state
  logic [N_LINES-1:0]             line_mask;
  logic [N_LINES-1:0]             line_swt;
  logic [N_LINES-1:0][N_CPUS-1:0] line_tgt;
  logic [N_LINES-1:0]             evt_mask;

  irqc_regs #(.N_LINES(N_LINES), .N_CPUS(N_CPUS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_go    (wr_go),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .evt_mask (evt_mask),
    .mask_q   (line_mask),
    .swt_q    (line_swt),
    .tgt_q    (line_tgt)
  );

  // per-processor arbitration
  logic [N_LINES-1:0] active;
  logic [N_CPUS-1:0]  win_any;
  logic [IDX_W-1:0]   win_idx [N_CPUS];

  assign active = (line_in | line_swt) & ~line_mask;

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    logic [N_LINES-1:0] elig;
    always_comb begin
      for (int i = 0; i < N_LINES; i++) elig[i] = active[i] & line_tgt[i][c];
    end
    irqc_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_pick (
      .req (elig),
      .any (win_any[c]),
      .idx (win_idx[c])
    );
  end

  assign irq_out = win_any;

  // event selection for the reading processor
  logic             cpu_ok;
  logic             ev_any;
  logic [IDX_W-1:0] ev_idx;
  logic             ev_take;

  assign cpu_ok = 32'(bus_cpu) < N_CPUS;

  always_comb begin
    ev_any = 1'b0;
    ev_idx = '0;
    for (int c = 0; c < N_CPUS; c++) begin
      if (cpu_ok && bus_cpu == CPU_W'(c)) begin
        ev_any = win_any[c];
        ev_idx = win_idx[c];
      end
    end
  end

  assign ev_take = rd_go && (bus_addr[11:2] == WA_EVENT) && ev_any;

  always_comb begin
    evt_mask = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (ev_take && ev_idx == IDX_W'(i)) evt_mask[i] = 1'b1;
    end
  end

  // read data
  logic [DATA_W-1:0] mask_word;
  logic [DATA_W-1:0] swt_word;
  logic [DATA_W-1:0] tgt_word;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    mask_word = '0;
    swt_word  = '0;
    tgt_word  = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (bus_addr[6:2] == 5'(i / 32)) begin
        mask_word[i % 32] = line_mask[i];
        swt_word[i % 32]  = line_swt[i];
      end
      if (bus_addr[9:2] == 8'(i)) tgt_word[N_CPUS-1:0] = line_tgt[i];
    end
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr[11:2] == WA_INFO) begin
      rd_val = {16'd0, 16'(N_LINES)};
    end else if (bus_addr[11:2] == WA_WHOAMI) begin
      rd_val = DATA_W'(bus_cpu);
    end else if (bus_addr[11:2] == WA_EVENT) begin
      if (ev_any) rd_val = {EVT_TYPE_LINE, 16'(ev_idx)};
    end else if (bus_addr[11:7] == RG_MASK_SET || bus_addr[11:7] == RG_MASK_CLR) begin
      rd_val = mask_word;
    end else if (bus_addr[11:7] == RG_SWT_SET || bus_addr[11:7] == RG_SWT_CLR) begin
      rd_val = swt_word;
    end else if (bus_addr[11:10] == RG_TARGET) begin
      rd_val = tgt_word;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_go) rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int N_CPUS  = 4,
  parameter int CPU_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [CPU_W-1:0]    bus_cpu,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [N_CPUS-1:0]   irq_out,
  input logic [N_LINES-1:0]  line_mask
);
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic sel_prev;
  logic ev_start;
  logic cpu_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= bus_sel;
  end

  assign ev_start = bus_sel && !sel_prev && !bus_we && bus_addr[11:2] == WA_EVENT;
  assign cpu_irq  = (32'(bus_cpu) < N_CPUS) && irq_out[bus_cpu];

  // R6: a returned line is masked once the read data is visible
  p_automask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (bus_rdata[31:16] != EVT_TYPE_LINE) || line_mask[bus_rdata[IDX_W-1:0]]);

  // R7: nothing pending for the reader gives a zero event word
  p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !cpu_irq) |=> bus_rdata == '0);

  // R9: a raised request yields a line event
  p_hit_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && cpu_irq) |=> bus_rdata[31:16] == EVT_TYPE_LINE);

  // R10: a stalled access does not repeat side effects or change read data
  p_stall_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && sel_prev) |=> $stable(line_mask));

  p_stall_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && sel_prev) |=> $stable(bus_rdata));

  // R9: with every line masked no request can be raised
  p_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&line_mask) |-> irq_out == '0);
endmodule

bind irqc_top irqc_checker #(
  .N_LINES (N_LINES),
  .N_CPUS  (N_CPUS),
  .CPU_W   (CPU_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_cpu   (bus_cpu),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .line_mask (line_mask)
);

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
  localparam int NL = 64;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] line_in = '0;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [NL-1:0] hw_m;
  logic [NL-1:0] swt_m;
  logic [NL-1:0] mask_m;
  int            tgt_m [NL];

  always #2 clk = ~clk;

  irqc_top #(.N_LINES(NL), .N_CPUS(NC)) i_irqc_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .line_in(line_in), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // one access held for two cycles; r is sampled after the first edge
  task automatic access(input int cpu, input bit we, input int addr, input logic [31:0] d,
                        output logic [31:0] r);
    logic [31:0] r2;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = 12'(addr); bus_wdata = d; bus_cpu = 2'(cpu);
    @(negedge clk);
    r = bus_rdata;
    @(negedge clk);
    r2 = bus_rdata;
    bus_sel = 1'b0; bus_we = 1'b0;
    if (!we) chk(r2 == r, "R10 read data held over stall", r2, r);
  endtask

  task automatic wr(input int cpu, input int addr, input logic [31:0] d);
    logic [31:0] dummy;
    access(cpu, 1'b1, addr, d, dummy);
  endtask

  task automatic rd(input int cpu, input int addr, output logic [31:0] r);
    access(cpu, 1'b0, addr, 32'd0, r);
  endtask

  function automatic logic [31:0] exp_event(input int cpu);
    for (int n = 0; n < NL; n++) begin
      if ((hw_m[n] | swt_m[n]) && !mask_m[n] && tgt_m[n][cpu]) return {16'd1, 16'(n)};
    end
    return 32'd0;
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] v = '0;
    for (int c = 0; c < NC; c++) v[c] = exp_event(c) != 0;
    return v;
  endfunction

  task automatic set_target(input int n, input int cpu);
    wr(0, 'h400 + 4 * n, 32'(1) << cpu);
    tgt_m[n] = 1 << cpu;
  endtask

  // reads the event word, compares it with the model and updates the model
  task automatic event_check(input int cpu, input string req);
    logic [31:0] r;
    logic [31:0] e;
    e = exp_event(cpu);
    rd(cpu, 'h008, r);
    chk(r == e, req, r, e);
    if (e != 0) mask_m[e[5:0]] = 1'b1;
  endtask

  task automatic mask_words_check(input string req);
    logic [31:0] r;
    for (int w = 0; w < NL / 32; w++) begin
      rd(w % NC, 'h100 + 4 * w, r);
      chk(r == mask_m[w*32 +: 32], req, r, mask_m[w*32 +: 32]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    hw_m = '0; swt_m = '0; mask_m = '1;
    for (int n = 0; n < NL; n++) tgt_m[n] = 1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    line_in = '1; hw_m = '1;
    @(negedge clk);
    chk(irq_out == '0, "R1 irq_out low with all lines masked", 32'(irq_out), 32'd0);
    mask_words_check("R1 mask words all set");
    for (int w = 0; w < NL / 32; w++) begin
      rd(0, 'h200 + 4 * w, r);
      chk(r == 32'd0, "R1 software-trigger word clear", r, 32'd0);
    end
    for (int n = 0; n < NL; n += 9) begin
      rd(1, 'h400 + 4 * n, r);
      chk(r == 32'd1, "R1 target reset to processor 0", r, 32'd1);
    end
    event_check(0, "R7 event zero while all masked");
    line_in = '0; hw_m = '0;

    // R8 info and who-am-I
    rd(2, 'h000, r);
    chk(r[15:0] == 16'(NL), "R8 info line count", r, 32'(NL));
    for (int c = 0; c < NC; c++) begin
      rd(c, 'h004, r);
      chk(r == 32'(c), "R8 who-am-I", r, 32'(c));
    end

    // single-line sweep: R2 R4 R5 R6 R9
    for (int n = 0; n < NL; n++) begin
      int own = n % NC;
      int other = (n + 1) % NC;
      line_in = '0; line_in[n] = 1'b1;
      hw_m = line_in;
      set_target(n, own);
      wr(0, 'h180 + 4 * (n / 32), 32'(1) << (n % 32));
      mask_m[n] = 1'b0;
      @(negedge clk);
      chk(irq_out == exp_irq(), "R9 irq_out follows routed line", 32'(irq_out), 32'(exp_irq()));
      event_check(other, "R4 non-owner sees no event");
      event_check(own, "R5 owner event returns line");
      chk(irq_out == '0, "R6 irq_out drops after event read", 32'(irq_out), 32'd0);
      rd(0, 'h180 + 4 * (n / 32), r);
      chk(r == mask_m[(n/32)*32 +: 32], "R6 read masked only the winner", r, mask_m[(n/32)*32 +: 32]);
    end
    line_in = '0; hw_m = '0;

    // R2 zero bits in set/clear writes change nothing
    wr(0, 'h180, 32'h0000_00F0); mask_m[7:4] = 4'h0;
    wr(0, 'h100, 32'h0000_0030); mask_m[5:4] = 2'b11;
    mask_words_check("R2 set and clear touch only 1 bits");

    // mixed patterns drained per processor: R3 R4 R5 R6 R7 R10
    for (int p = 0; p < 6; p++) begin
      logic [NL-1:0] hp;
      logic [NL-1:0] sp;
      hp = {$urandom, $urandom};
      sp = {$urandom, $urandom} & ~hp & {$urandom, $urandom};
      if (p == 0) begin hp = '0; sp = 64'h8000_0001_0000_0100; end
      if (p == 1) begin hp = 64'hFFFF_FFFF_FFFF_FFFF; sp = '0; end
      line_in = hp; hw_m = hp;
      wr(0, 'h280, 32'hFFFF_FFFF); wr(0, 'h284, 32'hFFFF_FFFF);
      wr(0, 'h200, sp[31:0]);      wr(0, 'h204, sp[63:32]);
      swt_m = sp;
      for (int n = 0; n < NL; n++) set_target(n, (p == 1) ? 0 : int'($urandom % NC));
      wr(0, 'h180, 32'hFFFF_FFFF); wr(0, 'h184, 32'hFFFF_FFFF);
      mask_m = '0;
      @(negedge clk);
      chk(irq_out == exp_irq(), "R3 irq_out with hardware OR software request", 32'(irq_out), 32'(exp_irq()));
      for (int c = 0; c < NC; c++) begin
        for (int k = 0; k < NL + 1; k++) begin
          logic [31:0] e;
          e = exp_event(c);
          event_check(c, "R5 drain returns lowest qualifying line");
          if (e == 0) break;
        end
        chk(irq_out[c] == 1'b0, "R7 processor drained", 32'(irq_out[c]), 32'd0);
      end
      mask_words_check("R10 one mask per stalled event read");
      rd(3, 'h204, r);
      chk(r == swt_m[63:32], "R3 software-trigger readback", r, swt_m[63:32]);
    end

    line_in = '0;
    summary();
    $finish;
  end
endmodule